// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block sits behind a narrow bus port and opens a small aperture onto two much larger spaces. A 32-bit pointer register and a 4-byte data window let software reach either a byte-addressed video memory or the wider register space by indirection. Through the window, an access goes to memory when the pointer's top bit is set. With that bit clear, the access is forwarded to a register address formed from the pointer plus the byte offset inside the window. Pointer values that would land back on the aperture itself are refused and flagged.

Requests of 1, 2 or 4 bytes enter on a valid/ready channel. Each accepted request, read or write, returns exactly one response on a second valid/ready channel. A request is taken only while no response is waiting, or in the same cycle that the waiting response is consumed. Downstream back-pressure therefore stalls the request side directly. All data is little-endian. Direct addresses also reach a simple register file and a read-only mirror of configuration data, both through the same byte-lane logic.

Top module: `ix_window_bridge`

## Requirements
- R1: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high when no response is pending or when rsp_ready is high. The response appears on rsp_valid in the cycle after acceptance and holds with stable rsp_rdata until a cycle with rsp_ready high.
- R2: The pointer register sits at byte addresses 0x000 to 0x003. Every write to it clears bits 1:0. Reads return its value. Its reset value is 0.
- R3: The data window is at 0x004 to 0x007. When pointer bit 31 is set, a window access targets memory byte pointer[30:0], whatever the window byte offset. Memory is little-endian: that byte is carried on bits 7:0.
- R4: A memory access of n bytes is carried out only when pointer[30:0] + n is no more than MEM_BYTES. Otherwise a write changes nothing and a read returns 0.
- R5: When pointer bit 31 is clear and the pointer exceeds 0x007, a window access at address a is carried out at register address pointer + (a - 0x004).
- R6: When pointer bit 31 is clear and the pointer is at most 0x007, a window access changes nothing and reads 0. err_pulse is high for exactly the first cycle of its response. err_sticky rises with it and stays high until reset.
- R7: req_size 0, 1 and 2 mean 1, 2 and 4 bytes, and 3 means 4 bytes. A register read returns the bytes from offset addr[1:0] upward in the low bits, zero-extended. A write places the low bytes of req_wdata at that offset. Bytes that fall past byte 3 of the word are dropped, and a 4-byte access at offset 0 replaces the whole word.
- R8: Register k of NREGS sits at REG_BASE + 4k (default 0x100), resets to 0 and is read/write.
- R9: Addresses 0xF00 to 0xFFF read the word {CFG_SEED[31:8], 2'b00, addr[7:2]} through the R7 lane rules. Writes there are ignored.
- R10: Reads of any other address return 0, and writes to them change nothing.
- R11: The response to a write carries rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address in the register aperture |
| req_size | input | 2 | Access size code (R7) |
| req_wdata | input | 32 | Write data, low bytes used |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| err_pulse | output | 1 | Rejected window access, one cycle |
| err_sticky | output | 1 | A rejected access has occurred since reset |

## Verification
A request accepted at edge k has its write effect at that same edge. Its response data and err_pulse are due at the output one register later, so they are visible from edge k and sampled at the falling edge after it. err_sticky follows the same timing. req_ready is combinational from the pending flag and rsp_ready, so it is due in the same cycle. The bench's behavioural model advances at each rising edge with exactly that latency. It compares every output at the following falling edge, and stimulus changes only after that comparison, so stalled responses are checked for stability on each held cycle.

// File: rtl/ix_pkg.sv
package ix_pkg;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_INDEX, TGT_MEM, TGT_REG, TGT_CFG, TGT_REJECT
  } tgt_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ix_lanes.sv
module ix_lanes (
  input  logic [1:0]  off,
  input  logic [2:0]  nbytes,
  input  logic [31:0] wdata,
  input  logic [31:0] rword,
  output logic [31:0] wshift,
  output logic [3:0]  be,
  output logic [31:0] rdata
);
  logic [31:0] rsh;
  logic [31:0] mask;

  for (genvar k = 0; k < 4; k++) begin : g_be
    assign be[k] = (3'(k) >= {1'b0, off}) && ((3'(k) - {1'b0, off}) < nbytes);
  end

  assign wshift = wdata << {off, 3'b000};
  assign rsh    = rword >> {off, 3'b000};
  assign mask   = (nbytes == 3'd1) ? 32'h0000_00FF :
                  (nbytes == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rdata  = rsh & mask;
endmodule

// File: rtl/ix_regfile.sv
module ix_regfile #(
  parameter int NREGS = 16,
  localparam int RIW  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RIW-1:0] idx,
  input  logic [3:0]     be,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);
  logic [31:0] regs [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[r][8*b +: 8] <= '0;
        else if (we && be[b] && (idx == RIW'(r)))
          regs[r][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = (int'(idx) < NREGS) ? regs[idx] : '0;
endmodule

// File: rtl/ix_vidmem.sv
module ix_vidmem #(
  parameter int MEM_BYTES = 256,
  localparam int MAW      = $clog2(MEM_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [MAW-1:0] addr,
  input  logic [2:0]     nbytes,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);
  logic [7:0] mem [MEM_BYTES];

  for (genvar k = 0; k < 4; k++) begin : g_rd
    logic [MAW:0] pos;
    assign pos = {1'b0, addr} + (MAW+1)'(k);
    assign rdata[8*k +: 8] = (pos < (MAW+1)'(MEM_BYTES)) ? mem[pos[MAW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (we) begin
      for (int k = 0; k < 4; k++)
        if (3'(k) < nbytes) mem[MAW'(addr + MAW'(k))] <= wdata[8*k +: 8];
    end
  end
endmodule

// File: rtl/ix_window_bridge.sv
module ix_window_bridge #(
  parameter int          AW        = 14,
  parameter int          NREGS     = 16,
  parameter logic [31:0] REG_BASE  = 32'h0000_0100,
  parameter int          MEM_BYTES = 256,
  parameter logic [31:0] CFG_SEED  = 32'hA5C3_1E00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          err_pulse,
  output logic          err_sticky
);
  import ix_pkg::*;

  localparam int          WIN_BASE = 4;
  localparam int          WIN_LAST = WIN_BASE + 3;
  localparam int          MAW      = $clog2(MEM_BYTES);
  localparam int          RIW      = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [31:0] REG_END  = REG_BASE + 32'(4 * NREGS);
  localparam logic [31:0] CFG_LO   = 32'h0000_0F00;
  localparam logic [31:0] CFG_HI   = 32'h0000_0FFF;

  logic [31:0] index_q;
  logic        rsp_valid_q, err_pulse_q, err_sticky_q;
  logic [31:0] rsp_rdata_q;

  tgt_e        tgt;
  logic [31:0] ea;
  logic [2:0]  nb;
  logic        acc, mem_inb;
  logic [1:0]  lane_off;
  logic [31:0] rword, lane_rdata, wshift, bmask, reg_rdata, mem_rdata, cfg_word, rd_val;
  logic [3:0]  be;

  function automatic tgt_e classify(input logic [31:0] a);
    if (a >= REG_BASE && a < REG_END) return TGT_REG;
    if (a >= CFG_LO && a <= CFG_HI)   return TGT_CFG;
    return TGT_NONE;
  endfunction

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_comb begin
    nb  = size_to_bytes(req_size);
    tgt = TGT_NONE;
    ea  = '0;
    if (req_addr < AW'(WIN_BASE)) begin
      tgt = TGT_INDEX;
      ea  = 32'(req_addr);
    end else if (req_addr <= AW'(WIN_LAST)) begin
      if (index_q[31]) begin
        tgt = TGT_MEM;
      end else if (index_q > 32'(WIN_LAST)) begin
        ea  = index_q + {30'b0, req_addr[1:0]};
        tgt = classify(ea);
      end else begin
        tgt = TGT_REJECT;
      end
    end else begin
      ea  = 32'(req_addr);
      tgt = classify(ea);
    end
  end

  assign mem_inb  = (32'(index_q[30:0]) + 32'(nb)) <= 32'(MEM_BYTES);
  assign cfg_word = {CFG_SEED[31:8], 2'b00, ea[7:2]};
  assign lane_off = (tgt == TGT_MEM) ? 2'b00 : ea[1:0];

  always_comb begin
    case (tgt)
      TGT_INDEX: rword = index_q;
      TGT_REG:   rword = reg_rdata;
      TGT_CFG:   rword = cfg_word;
      TGT_MEM:   rword = mem_rdata;
      default:   rword = '0;
    endcase
  end

  ix_lanes u_lanes (
    .off(lane_off), .nbytes(nb), .wdata(req_wdata), .rword(rword),
    .wshift(wshift), .be(be), .rdata(lane_rdata)
  );

  ix_regfile #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(acc && req_write && tgt == TGT_REG),
    .idx(RIW'((ea - REG_BASE) >> 2)), .be(be), .wdata(wshift),
    .rdata(reg_rdata)
  );

  ix_vidmem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(acc && req_write && tgt == TGT_MEM && mem_inb),
    .addr(index_q[MAW-1:0]), .nbytes(nb), .wdata(req_wdata),
    .rdata(mem_rdata)
  );

  always_comb begin
    rd_val = '0;
    if (!req_write) begin
      case (tgt)
        TGT_INDEX, TGT_REG, TGT_CFG: rd_val = lane_rdata;
        TGT_MEM:                     rd_val = mem_inb ? lane_rdata : '0;
        default:                     rd_val = '0;
      endcase
    end
  end

  assign bmask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q      <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_rdata_q  <= '0;
      err_pulse_q  <= 1'b0;
      err_sticky_q <= 1'b0;
    end else begin
      err_pulse_q <= 1'b0;
      if (acc) begin
        rsp_valid_q <= 1'b1;
        rsp_rdata_q <= rd_val;
        if (tgt == TGT_REJECT) begin
          err_pulse_q  <= 1'b1;
          err_sticky_q <= 1'b1;
        end
        if (req_write && tgt == TGT_INDEX)
          index_q <= ((index_q & ~bmask) | (wshift & bmask)) & ~32'h3;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign err_pulse  = err_pulse_q;
  assign err_sticky = err_sticky_q;
endmodule

// File: rtl/ix_window_bridge_chk.sv
module ix_window_bridge_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          err_pulse,
  input logic          err_sticky
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> rsp_valid && err_sticky && rsp_rdata == 32'h0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  p_wzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> rsp_valid && rsp_rdata == 32'h0);

  p_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_size == 2'd0 |=> rsp_rdata[31:8] == 24'h0);
endmodule

bind ix_window_bridge ix_window_bridge_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .err_pulse(err_pulse), .err_sticky(err_sticky)
);

// File: tb/tb_ix_window_bridge.sv
`timescale 1ns/1ps
module tb_ix_window_bridge;
  localparam int          AW   = 14;
  localparam int          NR   = 16;
  localparam int          RB   = 32'h100;
  localparam int          MB   = 256;
  localparam logic [31:0] SEED = 32'hA5C3_1E00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, err_pulse, err_sticky;
  logic [31:0] rsp_rdata;

  always #4 clk = ~clk;

  ix_window_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  int nvec = 0, nerr = 0;
  bit done = 0;
  bit stall_en = 0;
  string cur_tag = "R8";

  // behavioural reference state
  byte unsigned m_mem [MB];
  int unsigned  m_regs [NR];
  int unsigned  m_idx;
  bit           m_rv, m_pulse, m_sticky;
  int unsigned  m_rdata;
  string        m_tag = "R1";

  function automatic int unsigned lane_read(int unsigned w, int off, int n);
    int unsigned r = 0;
    for (int k = 0; k < n; k++)
      if (off + k < 4) r |= ((w >> (8 * (off + k))) & 32'hFF) << (8 * k);
    return r;
  endfunction

  function automatic int unsigned lane_write(int unsigned w, int off, int n, int unsigned d);
    for (int k = 0; k < n; k++)
      if (off + k < 4) begin
        w &= ~(32'hFF << (8 * (off + k)));
        w |= ((d >> (8 * k)) & 32'hFF) << (8 * (off + k));
      end
    return w;
  endfunction

  // returns read data; sets rej
  function automatic int unsigned ref_access(bit wr, int unsigned a, int sz,
                                             int unsigned d, output bit rej);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int unsigned e, w, r;
    rej = 0;
    r = 0;
    if (a < 4) e = a;
    else if (a < 8) begin
      if (m_idx[31]) begin
        int unsigned i = m_idx & 32'h7FFF_FFFF;
        if (i + n <= MB)
          for (int k = 0; k < n; k++)
            if (wr) m_mem[i + k] = byte'(d >> (8 * k));
            else    r |= int'(m_mem[i + k]) << (8 * k);
        return wr ? 0 : r;
      end else if (m_idx > 7) e = m_idx + (a - 4);
      else begin rej = 1; return 0; end
    end else e = a;
    if (e < 4) begin
      if (wr) m_idx = lane_write(m_idx, e % 4, n, d) & ~32'h3;
      else r = lane_read(m_idx, e % 4, n);
    end else if (e >= RB && e < RB + 4 * NR) begin
      if (wr) m_regs[(e - RB) / 4] = lane_write(m_regs[(e - RB) / 4], e % 4, n, d);
      else r = lane_read(m_regs[(e - RB) / 4], e % 4, n);
    end else if (e >= 32'hF00 && e <= 32'hFFF) begin
      if (!wr) r = lane_read({SEED[31:8], 2'b00, e[7:2]}, e % 4, n);
    end
    return wr ? 0 : r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MB; i++) m_mem[i] = 0;
      for (int i = 0; i < NR; i++) m_regs[i] = 0;
      m_idx = 0; m_rv = 0; m_pulse = 0; m_sticky = 0; m_rdata = 0;
    end else begin
      bit acc, rej;
      acc = req_valid && (!m_rv || rsp_ready);
      m_pulse = 0;
      if (acc) begin
        m_rdata = ref_access(req_write, 32'(req_addr), int'(req_size), req_wdata, rej);
        m_rv = 1;
        m_pulse = rej;
        if (rej) m_sticky = 1;
        m_tag = cur_tag;
      end else if (rsp_ready) m_rv = 0;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1", "req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      chk("R1", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk(m_tag, "rsp_rdata", rsp_rdata, m_rdata);
      chk("R6", "err_pulse", 32'(err_pulse), 32'(m_pulse));
      chk("R6", "err_sticky", 32'(err_sticky), 32'(m_sticky));
    end
  end

  always @(negedge clk) begin
    #2;
    rsp_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic issue(bit wr, int unsigned a, int sz, int unsigned d, string tag);
    @(negedge clk); #2;
    cur_tag = tag;
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_size = 2'(sz); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #3; end
  endtask

  task automatic idle(int n);
    @(negedge clk); #2;
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    // R8: reset values
    issue(0, 32'h100, 2, 0, "R8");
    issue(0, 32'h13C, 2, 0, "R8");
    // R2: pointer write clears low bits
    issue(1, 32'h000, 2, 32'h8000_0013, "R2");
    issue(0, 32'h000, 2, 0, "R2");
    issue(1, 32'h001, 0, 32'h0000_0057, "R2");
    issue(0, 32'h000, 2, 0, "R2");
    // R3: memory path, little-endian, window offset ignored
    issue(1, 32'h000, 2, 32'h8000_0010, "R3");
    issue(1, 32'h004, 2, 32'h4433_2211, "R3");
    issue(0, 32'h005, 0, 0, "R3");
    issue(0, 32'h007, 2, 0, "R3");
    issue(0, 32'h006, 1, 0, "R3");
    // R4: bounds
    issue(1, 32'h000, 2, 32'h8000_00FC, "R4");
    issue(1, 32'h004, 2, 32'hDEAD_BEEF, "R4");
    issue(0, 32'h004, 2, 0, "R4");
    issue(1, 32'h000, 2, 32'h8000_0100, "R4");
    issue(1, 32'h004, 0, 32'h77, "R4");
    issue(0, 32'h004, 0, 0, "R4");
    // R5: forwarding
    issue(1, 32'h000, 2, 32'h0000_0100, "R5");
    issue(1, 32'h004, 2, 32'hCAFE_F00D, "R5");
    issue(1, 32'h000, 2, 32'h0000_0104, "R5");
    issue(1, 32'h006, 1, 32'h0000_9988, "R5");
    issue(0, 32'h104, 2, 0, "R5");
    issue(0, 32'h100, 2, 0, "R5");
    issue(1, 32'h000, 2, 32'h0000_0F40, "R5");
    issue(0, 32'h005, 1, 0, "R5");
    // R6: rejected window accesses
    issue(1, 32'h000, 2, 32'h0000_0007, "R6");
    issue(0, 32'h004, 2, 0, "R6");
    issue(1, 32'h004, 2, 32'h1111_1111, "R6");
    issue(0, 32'h000, 2, 0, "R6");
    issue(1, 32'h000, 2, 32'h0000_0008, "R10");
    issue(0, 32'h004, 2, 0, "R10");
    // R7: byte lanes
    issue(1, 32'h108, 2, 32'hA1B2_C3D4, "R7");
    issue(1, 32'h109, 0, 32'hFFFF_FF5A, "R7");
    issue(1, 32'h10B, 1, 32'h0000_6677, "R7");
    issue(0, 32'h10A, 1, 0, "R7");
    issue(0, 32'h10B, 2, 0, "R7");
    issue(0, 32'h108, 3, 0, "R7");
    // R9: configuration mirror
    issue(0, 32'hF00, 2, 0, "R9");
    issue(0, 32'hF45, 1, 0, "R9");
    issue(1, 32'hF08, 2, 32'h1234_5678, "R9");
    issue(0, 32'hF08, 2, 0, "R9");
    // R10 / R11: undecoded and write responses
    issue(1, 32'h200, 2, 32'h5555_5555, "R11");
    issue(0, 32'h200, 2, 0, "R10");
    issue(0, 32'h080, 0, 0, "R10");
    idle(3);
    // R1: mixed traffic under response back-pressure
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 8;
      int unsigned a, d;
      d = $urandom;
      case (sel)
        0: begin a = 0; d = (d[0] ? 32'h8000_0000 : 0) | ($urandom % 32'h120); end
        1, 2: a = 4 + ($urandom % 4);
        3, 4: a = RB + ($urandom % (4 * NR));
        5: a = 32'hF00 + ($urandom % 256);
        6: a = $urandom % 4;
        default: a = 32'h140 + ($urandom % 64);
      endcase
      issue(sel == 0 ? 1'b1 : bit'($urandom % 2), a, $urandom % 4, d, "R1");
      if ($urandom % 5 == 0) idle($urandom % 3);
    end
    idle(4);
    stall_en = 0;
    idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule